// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block catches a program that has stopped making progress. Software picks one of eight timeout periods, turns the watchdog on, and then has to write a RUN strobe over and over, each time before the selected interval runs out. If a strobe comes too late, the block raises one of two requests: a system-reset request or a non-maskable interrupt request. The mode register selects which one.

A free-running prescaler on the system clock feeds a small watchdog counter. A RUN strobe clears the watchdog counter but leaves the prescaler as it is. Because the prescaler keeps its phase, the first count step after a restart arrives early, and the real timeout can be up to one count step shorter than nominal. The block has two power-mode inputs. In halt, time keeps running. In stop, both counters freeze.

Writes go through a strobe with one select bit. Both registers read back continuously. Once counting has started it cannot be stopped, and the configuration is locked until the asynchronous reset.

Top module: `wdt_timer`

## Requirements
- R1: After rst_ni is released, rst_req_o and nmi_req_o are 0, mode_o reads 0x00 and period_o reads 0.
- R2: Writing the mode register (wr_sel_i = 0) uses these bits: bit 7 is RUN, bit 4 is enable and bit 3 is the action. A RUN write with bit 4 set starts counting, and mode_o then reads {running, 00, enable, action, 000}. A RUN write with bit 4 clear does not start counting, and no request follows.
- R3: The period register (wr_sel_i = 1, bits 2:0) selects a timeout of 2^(BASE_LOG2+c) clocks for codes c = 0 to 6, and 2^(BASE_LOG2+8) clocks for code 7.
- R4: The prescaler counts clocks from reset and is never cleared by RUN. A carry is an edge at which the prescaler's low (shift - CNT_W) bits are all ones, where shift is the exponent from R3. The expiry is registered at the 2^CNT_W-th carry after the RUN write edge, and a carry on the write edge itself is not counted.
- R5: Each later RUN write clears the watchdog count and restarts the full interval. Strobes that arrive in time never produce a request.
- R6: With action 0, an expiry gives a one-clock pulse on nmi_req_o in the clock after the expiry edge. The count wraps and keeps running, so the next pulse follows 2^shift clocks later.
- R7: With action 1, an expiry raises rst_req_o in the clock after the expiry edge. rst_req_o then stays high and counting stops until rst_ni clears the block.
- R8: halt_i has no effect on the timing.
- R9: While stop_i is high, the prescaler and the watchdog count hold their values and no request is raised. The timeout is extended by exactly the number of stopped clocks.
- R10: Once running, period writes are ignored. Mode writes change neither enable nor action, and a write with RUN = 0 does not stop the count.
- R11: Each expiry pulses exactly one of the two request outputs, selected by the action bit, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mode, 1 period |
| wr_data_i | input | 8 | Write data |
| halt_i | input | 1 | Halt power mode; counting continues |
| stop_i | input | 1 | Stop power mode; counting freezes |
| mode_o | output | 8 | Mode readback {running, 00, enable, action, 000} |
| period_o | output | 3 | Period-select readback |
| rst_req_o | output | 1 | System-reset request, held until reset |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
The hardest case to reach is the exact expiry edge. It depends on the prescaler phase at the moment RUN is written, and that phase cannot be seen at the ports. The bench keeps its own count of clocks that are not stopped since reset, reads the phase at each write edge, and derives the first carry and the expiry edge from R4. It varies the idle time before each start so that every period code begins from a different phase. It places a stop window in the middle of a run and a run of late-but-in-time restarts, which checks the timeout shift and the restart window against the same arithmetic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RUN_BIT = 7;
  localparam int EN_BIT  = 4;
  localparam int ACT_BIT = 3;

  typedef enum logic {
    SEL_MODE   = 1'b0,
    SEL_PERIOD = 1'b1
  } wdt_sel_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_STOP = 2'd2
  } wdt_pm_e;

  typedef struct packed {
    logic running;
    logic enable;
    logic act_rst;
  } wdt_mode_t;

  // log2 of the timeout in clocks for a period code; code 7 skips one step
  function automatic int period_log2(input int code, input int base);
    return (code == 7) ? base + 8 : base + code;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [7:0]      wr_data_i,
  output wdt_mode_t       mode_o,
  output logic [2:0]      period_o,
  output logic            restart_o
);
  wdt_mode_t  mode_q;
  logic [2:0] period_q;
  logic       wr_mode, wr_period;
  logic       unused_bits;

  assign wr_mode     = wr_en_i && (wr_sel_i == SEL_MODE);
  assign wr_period   = wr_en_i && (wr_sel_i == SEL_PERIOD);
  assign unused_bits = ^wr_data_i[6:5];

  // configuration locks once running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      period_q <= '0;
    end else if (!mode_q.running) begin
      if (wr_mode) begin
        mode_q.enable  <= wr_data_i[EN_BIT];
        mode_q.act_rst <= wr_data_i[ACT_BIT];
        mode_q.running <= wr_data_i[RUN_BIT] & wr_data_i[EN_BIT];
      end else if (wr_period) begin
        period_q <= wr_data_i[2:0];
      end
    end
  end

  assign restart_o = wr_mode && wr_data_i[RUN_BIT] &&
                     (mode_q.running || wr_data_i[EN_BIT]);
  assign mode_o    = mode_q;
  assign period_o  = period_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int CNT_W     = 8,
  parameter int PRESC_W   = BASE_LOG2 + 8 - CNT_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic [2:0] period_i,
  output logic       tick_o
);
  localparam int NUM_CODES = 8;

  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W-1:0] tap_mask [NUM_CODES];
  wdt_pm_e            pm;
  logic               count_en;

  always_comb begin
    if (stop_i)      pm = PM_STOP;
    else if (halt_i) pm = PM_HALT;
    else             pm = PM_RUN;
  end
  assign count_en = (pm != PM_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       presc_q <= '0;
    else if (count_en) presc_q <= presc_q + 1'b1;
  end

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_tap
    localparam int TAP = period_log2(c, BASE_LOG2) - CNT_W;
    assign tap_mask[c] = {PRESC_W{1'b1}} >> (PRESC_W - TAP);
  end

  // carry out of the selected low bits
  assign tick_o = count_en && (&(presc_q | ~tap_mask[period_i]));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic active_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (active_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = active_i && tick_i && !restart_i && (&cnt_q);
endmodule

// File: rtl/wdt_req.sv
module wdt_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic act_rst_i,
  output logic rst_req_o,
  output logic nmi_req_o
);
  logic rst_q, nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rst_q <= rst_q | (expire_i & act_rst_i);
      nmi_q <= expire_i & ~act_rst_i;
    end
  end

  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int CNT_W     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       halt_i,
  input  logic       stop_i,
  output logic [7:0] mode_o,
  output logic [2:0] period_o,
  output logic       rst_req_o,
  output logic       nmi_req_o
);
  localparam int PRESC_W = BASE_LOG2 + 8 - CNT_W;

  wdt_mode_t  mode;
  logic [2:0] period;
  logic       restart, tick, active, expire;

  wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode),
    .period_o  (period),
    .restart_o (restart)
  );

  wdt_prescaler #(
    .BASE_LOG2 (BASE_LOG2),
    .CNT_W     (CNT_W),
    .PRESC_W   (PRESC_W)
  ) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt_i),
    .stop_i   (stop_i),
    .period_i (period),
    .tick_o   (tick)
  );

  // a raised reset request ends counting
  assign active = mode.running && !rst_req_o;

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (tick),
    .active_i  (active),
    .expire_o  (expire)
  );

  wdt_req u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .act_rst_i (mode.act_rst),
    .rst_req_o (rst_req_o),
    .nmi_req_o (nmi_req_o)
  );

  assign mode_o   = {mode.running, 2'b00, mode.enable, mode.act_rst, 3'b000};
  assign period_o = period;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic [7:0] mode_o,
  input logic [2:0] period_o,
  input logic       rst_req_o,
  input logic       nmi_req_o
);
  assert_req_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && nmi_req_o));

  assert_nmi_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |=> !nmi_req_o);

  assert_rst_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  assert_run_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[7] |=> mode_o[7]);

  assert_period_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[7] |=> $stable(period_o));

  assert_stop_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!nmi_req_o && !$rose(rst_req_o)));

  assert_req_needs_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_o || rst_req_o) |-> mode_o[7]);

  assert_run_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[7] |-> mode_o[4]);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_i    (stop_i),
  .mode_o    (mode_o),
  .period_o  (period_o),
  .rst_req_o (rst_req_o),
  .nmi_req_o (nmi_req_o)
);

// File: tb/wdt_timer_tb.sv
`timescale 1ns/1ps
module wdt_timer_tb;
  localparam int B  = 5;
  localparam int CW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       halt = 1'b0, stop = 1'b0;
  logic [7:0] mode_rd;
  logic [2:0] period_rd;
  logic       rst_req, nmi_req;

  int checks = 0;
  int fails  = 0;
  int unsigned pcnt;

  always #4 clk = ~clk;

  wdt_timer #(.BASE_LOG2(B), .CNT_W(CW)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .halt_i    (halt),
    .stop_i    (stop),
    .mode_o    (mode_rd),
    .period_o  (period_rd),
    .rst_req_o (rst_req),
    .nmi_req_o (nmi_req)
  );

  // clocks seen since reset, excluding stopped ones (R4, R9)
  always @(posedge clk or negedge rst_n)
    if (!rst_n)     pcnt <= 0;
    else if (!stop) pcnt <= pcnt + 1;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; stop = 1'b0; halt = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // RUN write, then follow both request outputs up to the expected expiries
  task automatic watch(input int code, input int act, input logic [7:0] data,
                       input logic [7:0] exp_mode, input int stop_at,
                       input int stop_len, input bit halt_v, input string tag);
    int tap, t, p, d, n1, n2, last, k, i, bad_k, got_v, exp_v;
    bit bad, run_ok;
    tap = B + ((code == 7) ? 8 : code) - CW;
    t = 1 << tap;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = data;
    p = int'(pcnt);
    @(negedge clk);
    wr_en = 1'b0;
    check(mode_rd == exp_mode, $sformatf("%s mode readback", tag), mode_rd, exp_mode);
    d = (t - 1 - (p % t));
    if (d == 0) d = t;
    n1 = d + ((1 << CW) - 1) * t;
    n2 = n1 + (t << CW);
    last = act ? n1 + 5 : n2 + 1;
    k = 0; i = 0; bad = 0; bad_k = 0; got_v = 0; exp_v = 0;
    while (k < last) begin
      i++;
      stop = (i >= stop_at) && (i < stop_at + stop_len);
      halt = halt_v;
      @(negedge clk);
      run_ok = !stop;
      if (run_ok) k++;
      if (!bad && ((nmi_req != (act == 0 && run_ok && (k == n1 || k == n2))) ||
                   (rst_req != (act != 0 && k >= n1)))) begin
        bad = 1; bad_k = k;
        got_v = {rst_req, nmi_req};
        exp_v = {(act != 0 && k >= n1), (act == 0 && run_ok && (k == n1 || k == n2))};
      end
    end
    stop = 1'b0; halt = 1'b0;
    check(!bad, $sformatf("%s code %0d step %0d {rst,nmi}", tag, code, bad_k), got_v, exp_v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit quiet;
    do_reset();
    // R1 reset state
    check(rst_req == 1'b0 && nmi_req == 1'b0, "R1 requests", {rst_req, nmi_req}, 0);
    check(mode_rd == 8'h00, "R1 mode", mode_rd, 0);
    check(period_rd == 3'd0, "R1 period", period_rd, 0);

    // R2 RUN without enable does nothing
    wr(1'b0, 8'h80);
    check(mode_rd == 8'h00, "R2 run without enable", mode_rd, 0);
    quiet = 1;
    repeat (600) begin
      @(negedge clk);
      if (rst_req || nmi_req) quiet = 0;
    end
    check(quiet, "R2 no request when disabled", !quiet, 0);

    // R3 R4 R6 R11 sweep of all period codes, NMI action, varied phase
    for (int c = 0; c < 8; c++) begin
      do_reset();
      wr(1'b1, 8'(c));
      repeat (c * 5 + 1) @(negedge clk);
      check(period_rd == 3'(c), "R3 period readback", period_rd, c);
      watch(c, 0, 8'h90, 8'h90, 0, 0, 1'b0, "R3 R4 R6 R11");
    end

    // R7 R8 reset action under halt
    do_reset();
    wr(1'b1, 8'd1);
    repeat (3) @(negedge clk);
    watch(1, 1, 8'h98, 8'h98, 0, 0, 1'b1, "R7 R8 R11");
    do_reset();
    check(rst_req == 1'b0 && mode_rd == 8'h00, "R7 cleared by reset", {rst_req, mode_rd}, 0);

    // R9 stop window mid-run
    do_reset();
    wr(1'b1, 8'd2);
    watch(2, 0, 8'h90, 8'h90, 10, 57, 1'b0, "R9");

    // R10 locked configuration, R5 timely restarts
    do_reset();
    wr(1'b1, 8'd0);
    wr(1'b0, 8'h90);
    wr(1'b1, 8'd7);
    check(period_rd == 3'd0, "R10 period write ignored", period_rd, 0);
    wr(1'b0, 8'h08);
    check(mode_rd == 8'h90, "R10 mode write ignored", mode_rd, 8'h90);
    quiet = 1;
    for (int j = 0; j < 10; j++) begin
      repeat (15 + j) begin
        @(negedge clk);
        if (rst_req || nmi_req) quiet = 0;
      end
      wr(1'b0, 8'h80);
      if (rst_req || nmi_req) quiet = 0;
    end
    check(quiet, "R5 no request with timely restarts", !quiet, 0);
    watch(0, 0, 8'h80, 8'h90, 0, 0, 1'b0, "R5 R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule